// File: doc/BRIEF.md
# Framed Register Job Requester

This block is the initiating side of a byte-wide framed job protocol. A local client hands it one command at a time: read or write, a 4-bit register address and, for writes, one data byte. The block turns the command into a request frame on an outgoing valid/ready stream whose beats carry first and last markers. It then takes the responder's answer frame on an incoming valid/ready stream and reports the outcome.

A read request is one beat marked both first and last. A write request is two beats: a header marked first, then the data byte marked last. The answer to a read has three beats (header, data, status). The answer to a write has two beats (header, status). The status byte is decoded into an error bit. If the responder breaks the expected framing, the block ends the job with a protocol-error flag.

Back-pressure works the same way on all three streams. A beat moves on a clock edge where valid and ready are both high. The block keeps an outgoing beat unchanged until it is taken. The command input is ready only while no job is in flight. The response input is ready only while an answer is awaited, so the responder may hold a beat on the response stream for as long as it needs.

Top module: `job_requester`

## Requirements
- R1: After reset, busy, req_valid, rsp_ready, done and done_proto_err are 0, and cmd_ready is 1.
- R2: A request header byte carries the operation code in bits 3:0 (0x0 for read, 0x1 for write) and the address in bits 7:4.
- R3: A read request is exactly one beat with req_first=1 and req_last=1.
- R4: A write request is a header beat with req_first=1 and req_last=0. It is followed by a second beat carrying cmd_wdata with req_first=0 and req_last=1.
- R5: While req_valid is high and req_ready is low, req_data, req_first and req_last hold their values on the next cycle. req_first and req_last are high only while req_valid is high.
- R6: rsp_ready rises in the cycle after the final request beat is accepted. It stays high until the job ends. Response beats offered while no answer is awaited are not accepted and produce no done.
- R7: A read answer of header (first=1, last=0), data (first=0, last=0) and status (first=0, last=1) ends the job with done_rdata equal to the data beat.
- R8: A write answer of header (first=1, last=0) and status (first=0, last=1) ends the job with done_rdata equal to 0.
- R9: A status byte of 0x00 gives done_err=0. Any other value (0x01 signals an error, for example an address above 7) gives done_err=1.
- R10: A response beat whose first/last markers do not match the expected position ends the job at once with done_proto_err=1, done_err=0 and done_rdata=0.
- R11: busy is high from the cycle after a command is accepted until the job ends. cmd_ready is low while busy, and commands offered then are not taken.
- R12: done is a single-cycle pulse in the cycle after the status beat (or the offending beat) is accepted. busy is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Local command offered |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 4 | Register address |
| cmd_wdata | input | 8 | Write data byte |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Responder takes request beat |
| req_data | output | 8 | Request beat byte |
| req_first | output | 1 | Beat opens a frame |
| req_last | output | 1 | Beat closes a frame |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Block takes response beat |
| rsp_data | input | 8 | Response beat byte |
| rsp_first | input | 1 | Response beat opens a frame |
| rsp_last | input | 1 | Response beat closes a frame |
| busy | output | 1 | Job in flight |
| done | output | 1 | One-cycle job completion pulse |
| done_rdata | output | 8 | Read data of the finished job |
| done_err | output | 1 | Status byte reported an error |
| done_proto_err | output | 1 | Answer frame was malformed |

## Verification
A wrong request-sequencer state shows on the request port in the next cycle. The bench would see a missing second write beat, wrong first/last markers, or req_valid lingering after the final beat. A wrong answer-parser state shows within one response beat. Either rsp_ready is wrong in the cycle after the last request beat, or done arrives early or late, or it arrives carrying a protocol error on a well-formed frame. A corrupted captured byte or status decode appears in the done pulse of the very job that caused it.

// File: rtl/jr_pkg.sv
package jr_pkg;

  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] OP_READ  = 4'h0;
  localparam logic [CMD_W-1:0] OP_WRITE = 4'h1;

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_DATA} tx_state_t;
  typedef enum logic [1:0] {RX_OFF, RX_HDR, RX_DATA, RX_FTR} rx_state_t;
  typedef enum logic [1:0] {BEAT_HEAD, BEAT_BODY, BEAT_TAIL, BEAT_BAD} beat_kind_t;

  function automatic beat_kind_t classify_beat(input logic first, input logic last);
    if (first && !last)      return BEAT_HEAD;
    else if (!first && !last) return BEAT_BODY;
    else if (!first && last)  return BEAT_TAIL;
    else                      return BEAT_BAD;
  endfunction

endpackage

// File: rtl/jr_req_tx.sv
module jr_req_tx
  import jr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DATA_W-1:0] req_data,
  output logic              req_first,
  output logic              req_last,
  output logic              sent
);

  localparam int ADDR_LSB = CMD_W;

  tx_state_t         state_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] wdata_q;
  logic              first_q;
  logic              last_q;
  logic              wr_q;
  logic [DATA_W-1:0] header;

  always_comb begin
    header = '0;
    header[CMD_W-1:0] = is_write ? OP_WRITE : OP_READ;
    header[ADDR_LSB +: ADDR_W] = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      data_q  <= '0;
      wdata_q <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (start) begin
            state_q <= TX_HDR;
            data_q  <= header;
            first_q <= 1'b1;
            last_q  <= !is_write;
            wdata_q <= wdata;
            wr_q    <= is_write;
          end
        end
        TX_HDR: begin
          if (req_ready) begin
            if (wr_q) begin
              state_q <= TX_DATA;
              data_q  <= wdata_q;
              first_q <= 1'b0;
              last_q  <= 1'b1;
            end else begin
              state_q <= TX_IDLE;
              data_q  <= '0;
              first_q <= 1'b0;
              last_q  <= 1'b0;
            end
          end
        end
        TX_DATA: begin
          if (req_ready) begin
            state_q <= TX_IDLE;
            data_q  <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q != TX_IDLE);
  assign req_data  = data_q;
  assign req_first = first_q;
  assign req_last  = last_q;
  assign sent      = req_valid && req_ready && last_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data) && $stable(req_first) && $stable(req_last)));

  // R5
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_first || req_last) |-> req_valid);

  // R3
  single_beat_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first && req_last) |-> (req_data[CMD_W-1:0] == OP_READ));

endmodule

// File: rtl/jr_rsp_rx.sv
module jr_rsp_rx
  import jr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              job_write,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_first,
  input  logic              rsp_last,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              proto_err
);

  rx_state_t         state_q;
  logic              wr_q;
  logic [DATA_W-1:0] cap_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              perr_q;
  logic              beat;
  beat_kind_t        kind;

  assign rsp_ready = (state_q != RX_OFF);
  assign beat      = rsp_valid && rsp_ready;
  assign kind      = classify_beat(rsp_first, rsp_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_OFF;
      wr_q    <= 1'b0;
      cap_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == RX_OFF) begin
        if (arm) begin
          state_q <= RX_HDR;
          wr_q    <= job_write;
          cap_q   <= '0;
        end
      end else if (beat) begin
        case (state_q)
          RX_HDR: begin
            if (kind == BEAT_HEAD) begin
              state_q <= wr_q ? RX_FTR : RX_DATA;
            end else begin
              state_q <= RX_OFF;
              done_q  <= 1'b1;
              perr_q  <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= '0;
            end
          end
          RX_DATA: begin
            if (kind == BEAT_BODY) begin
              cap_q   <= rsp_data;
              state_q <= RX_FTR;
            end else begin
              state_q <= RX_OFF;
              done_q  <= 1'b1;
              perr_q  <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= '0;
            end
          end
          RX_FTR: begin
            state_q <= RX_OFF;
            done_q  <= 1'b1;
            if (kind == BEAT_TAIL) begin
              perr_q  <= 1'b0;
              err_q   <= (rsp_data != '0);
              rdata_q <= wr_q ? '0 : cap_q;
            end else begin
              perr_q  <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= '0;
            end
          end
          default: state_q <= RX_OFF;
        endcase
      end
    end
  end

  assign done      = done_q;
  assign rdata     = rdata_q;
  assign err       = err_q;
  assign proto_err = perr_q;

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  perr_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && proto_err) |-> (!err && rdata == '0));

  // R6
  arm_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> rsp_ready);

endmodule

// File: rtl/job_requester.sv
module job_requester
  import jr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DATA_W-1:0] req_data,
  output logic              req_first,
  output logic              req_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_first,
  input  logic              rsp_last,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_err,
  output logic              done_proto_err
);

  logic cmd_fire;
  logic sent;
  logic job_wr_q;

  assign busy      = req_valid || rsp_ready;
  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) job_wr_q <= 1'b0;
    else if (cmd_fire) job_wr_q <= cmd_write;
  end

  jr_req_tx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_fire),
    .is_write  (cmd_write),
    .addr      (cmd_addr),
    .wdata     (cmd_wdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_data  (req_data),
    .req_first (req_first),
    .req_last  (req_last),
    .sent      (sent)
  );

  jr_rsp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (sent),
    .job_write (job_wr_q),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_first (rsp_first),
    .rsp_last  (rsp_last),
    .done      (done),
    .rdata     (done_rdata),
    .err       (done_err),
    .proto_err (done_proto_err)
  );

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (busy && req_valid && req_first));

  // R6
  phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ready && req_valid));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_job_requester.sv
module tb_job_requester;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic       cmd_write = 1'b0;
  logic [3:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       req_valid;
  logic       req_ready = 1'b0;
  logic [7:0] req_data;
  logic       req_first;
  logic       req_last;
  logic       rsp_valid = 1'b0;
  logic       rsp_ready;
  logic [7:0] rsp_data = '0;
  logic       rsp_first = 1'b0;
  logic       rsp_last = 1'b0;
  logic       busy;
  logic       done;
  logic [7:0] done_rdata;
  logic       done_err;
  logic       done_proto_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  job_requester dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_first(req_first), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_first(rsp_first), .rsp_last(rsp_last),
    .busy(busy), .done(done), .done_rdata(done_rdata),
    .done_err(done_err), .done_proto_err(done_proto_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic wr, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 busy after accept", busy, 1);
    chk("R11 cmd_ready low", cmd_ready, 0);
  endtask

  task automatic take_req(input logic [7:0] d, input logic f, input logic l, input int stall, input string tag);
    for (int i = 0; i < stall; i++) begin
      chk({tag, " stalled valid"}, req_valid, 1);
      chk({tag, " stalled beat"}, {req_data, req_first, req_last}, {d, f, l});
      @(negedge clk);
    end
    chk({tag, " valid"}, req_valid, 1);
    chk({tag, " beat"}, {req_data, req_first, req_last}, {d, f, l});
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic give_rsp(input logic [7:0] d, input logic f, input logic l);
    chk("R6 rsp_ready during answer", rsp_ready, 1);
    rsp_valid = 1'b1; rsp_data = d; rsp_first = f; rsp_last = l;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_first = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic chk_done(input logic [7:0] rd, input logic e, input logic pe, input string tag);
    chk({tag, " done"}, done, 1);
    chk({tag, " busy clear R12"}, busy, 0);
    chk({tag, " rdata"}, done_rdata, rd);
    chk({tag, " err"}, done_err, e);
    chk({tag, " proto"}, done_proto_err, pe);
    @(negedge clk);
    chk("R12 done single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 rsp_ready", rsp_ready, 0);
    chk("R1 done", done, 0);
    chk("R1 proto", done_proto_err, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_read_ok();
    send_cmd(1'b0, 4'h3, 8'h00);
    take_req(8'h30, 1'b1, 1'b1, 2, "R2 R3 R5 read hdr");
    chk("R6 rsp_ready after last req", rsp_ready, 1);
    chk("R3 no second beat", req_valid, 0);
    give_rsp(8'h30, 1'b1, 1'b0);
    give_rsp(8'hA5, 1'b0, 1'b0);
    give_rsp(8'h00, 1'b0, 1'b1);
    chk_done(8'hA5, 1'b0, 1'b0, "R7 R9 read ok");
  endtask

  task automatic t_read_err();
    send_cmd(1'b0, 4'hC, 8'h00);
    take_req(8'hC0, 1'b1, 1'b1, 0, "R2 read hi addr");
    give_rsp(8'hC0, 1'b1, 1'b0);
    give_rsp(8'h00, 1'b0, 1'b0);
    give_rsp(8'h01, 1'b0, 1'b1);
    chk_done(8'h00, 1'b1, 1'b0, "R9 read error");
  endtask

  task automatic t_write_ok();
    send_cmd(1'b1, 4'h5, 8'h6E);
    take_req(8'h51, 1'b1, 1'b0, 1, "R2 R4 write hdr");
    chk("R6 not ready mid request", rsp_ready, 0);
    take_req(8'h6E, 1'b0, 1'b1, 3, "R4 R5 write data");
    chk("R6 rsp_ready after write", rsp_ready, 1);
    give_rsp(8'h51, 1'b1, 1'b0);
    give_rsp(8'h00, 1'b0, 1'b1);
    chk_done(8'h00, 1'b0, 1'b0, "R8 write ok");
  endtask

  task automatic t_write_err();
    send_cmd(1'b1, 4'h9, 8'h12);
    take_req(8'h91, 1'b1, 1'b0, 0, "R4 write hdr b");
    take_req(8'h12, 1'b0, 1'b1, 0, "R4 write data b");
    give_rsp(8'h91, 1'b1, 1'b0);
    give_rsp(8'h01, 1'b0, 1'b1);
    chk_done(8'h00, 1'b1, 1'b0, "R8 R9 write error");
  endtask

  task automatic t_proto_write();
    send_cmd(1'b1, 4'h2, 8'h44);
    take_req(8'h21, 1'b1, 1'b0, 0, "R4 write hdr c");
    take_req(8'h44, 1'b0, 1'b1, 0, "R4 write data c");
    give_rsp(8'h21, 1'b1, 1'b0);
    give_rsp(8'h77, 1'b0, 1'b0);
    chk_done(8'h00, 1'b0, 1'b1, "R10 body after write hdr");
  endtask

  task automatic t_proto_read();
    send_cmd(1'b0, 4'h1, 8'h00);
    take_req(8'h10, 1'b1, 1'b1, 0, "R3 read hdr d");
    give_rsp(8'h00, 1'b0, 1'b1);
    chk_done(8'h00, 1'b0, 1'b1, "R10 tail without hdr");
  endtask

  task automatic t_idle_ignore();
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 8'h01; rsp_first = 1'b0; rsp_last = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 idle rsp_ready", rsp_ready, 0);
      chk("R6 idle no done", done, 0);
    end
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic t_busy_ignore();
    send_cmd(1'b0, 4'h6, 8'h00);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'hF; cmd_wdata = 8'hEE;
    take_req(8'h60, 1'b1, 1'b1, 2, "R11 read hdr while cmd held");
    chk("R11 cmd_ready busy", cmd_ready, 0);
    give_rsp(8'h60, 1'b1, 1'b0);
    give_rsp(8'h3C, 1'b0, 1'b0);
    cmd_valid = 1'b0;
    give_rsp(8'h00, 1'b0, 1'b1);
    chk_done(8'h3C, 1'b0, 1'b0, "R11 R7 job unaffected");
    chk("R11 no extra job", req_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_read_err();
    t_write_ok();
    t_write_err();
    t_proto_write();
    t_proto_read();
    t_idle_ignore();
    t_busy_ignore();
    t_read_ok();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule